// File: doc/BRIEF.md
# Predicated Vector-to-Scalar Instruction Expander

This block turns one decoded three-operand scalar instruction into a run of scalar micro-operations, one for each element of a vector of length VL. A small associative register table, loaded through a configuration write port, says which architectural registers act as vectors and which base register each one is redirected to. During expansion each vector operand steps through consecutive registers, one per element, while each scalar operand stays on its own register for the whole run. A predicate mask decides which elements are actually handed to the downstream micro-op queue.

The instruction arrives on a valid/ready handshake and is accepted only while no expansion is running. Micro-ops leave on a second valid/ready handshake, and downstream backpressure stalls the expansion. If a vector operand would step past the last integer register, the instruction is dropped and a one-cycle exception pulse is raised in its place.

Top module: `vec_expander`

## Requirements
- R1: After reset `inReady` is 1, `outValid` and `excValid` are 0, and every table entry is invalid, so every register behaves as a scalar.
- R2: A cycle with `cfgWrEn` high writes entry `cfgWrIdx` with the valid bit, 5-bit key, vector flag and 5-bit target. A register matches an entry that is valid and whose key equals the register number. When several entries match, the lowest index wins. A register with no match, or whose winning entry has the vector flag clear, is scalar and is not redirected.
- R3: When an operand (rd, rs1 or rs2) is a vector, its register number is replaced by the winning entry's target before expansion starts.
- R4: Elements i = 0 … VL−1 are considered in increasing order, and element i is emitted only when `predMask` bit i is 1. A `vecLen` value above MAX_VL is treated as MAX_VL. `vecLen` and `predMask` are sampled in the accept cycle.
- R5: In each emitted micro-op the opcode is copied unchanged, a vector operand equals its base plus i, and a scalar operand equals its own register number.
- R6: The element offset advances on masked-off elements too, so a vector operand in element i always uses base plus i.
- R7: If any vector operand has base + VL − 1 > 31 with VL ≥ 1, whatever the mask, `excValid` pulses high for exactly one cycle in the cycle after acceptance. The instruction is consumed and no micro-op is emitted.
- R8: When VL is 0, or every mask bit below VL is 0, the instruction is consumed and produces no micro-op and no exception.
- R9: `inReady` stays low from acceptance until the last element has been handed off. It is never high while `outValid` is high.
- R10: While `outValid` is high and `outReady` is low, the expansion holds. `outValid` stays high and the micro-op fields stay unchanged until the handoff, so no element is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction offered |
| inReady | output | 1 | Expander idle, instruction taken this cycle |
| inOp | input | OP_W | Opcode to replicate |
| inRd | input | 5 | Destination register |
| inRs1 | input | 5 | First source register |
| inRs2 | input | 5 | Second source register |
| vecLen | input | VL_W | Vector length, sampled on acceptance |
| predMask | input | MAX_VL | Per-element enable, sampled on acceptance |
| cfgWrEn | input | 1 | Table write strobe |
| cfgWrIdx | input | TAB_IDX_W | Table entry to write |
| cfgWrValid | input | 1 | Valid bit for the written entry |
| cfgWrKey | input | 5 | Architectural register the entry describes |
| cfgWrIsVec | input | 1 | Entry marks its register as a vector |
| cfgWrTarget | input | 5 | Redirected base register |
| outValid | output | 1 | Micro-op present |
| outReady | input | 1 | Downstream queue accepts the micro-op |
| outOp | output | OP_W | Micro-op opcode |
| outRd | output | 5 | Micro-op destination |
| outRs1 | output | 5 | Micro-op first source |
| outRs2 | output | 5 | Micro-op second source |
| excValid | output | 1 | Register-range exception pulse |

## Verification
The assertions assume that `outReady` is a plain level that the downstream side may drop at any time. They also assume that the table is not rewritten during the cycle in which an instruction is accepted, since the lookup reads the contents as they were before that edge. The stimulus writes table entries only while the expander is idle and never in the same cycle as an instruction. It holds `inValid` for exactly one accept cycle per instruction, and it drives `outReady` either constantly high or alternating every cycle, so that both the stall and the release paths are exercised.

// File: rtl/vexp_pkg.sv
package vexp_pkg;
  localparam int REG_W    = 5;
  localparam int NUM_REGS = 32;
  localparam int N_OPND   = 3;   // 0 = rd, 1 = rs1, 2 = rs2

  typedef logic [REG_W-1:0] regIdxT;

  typedef struct packed {
    logic   valid;
    regIdxT key;
    logic   isVec;
    regIdxT target;
  } tabEntryT;

  typedef struct packed {
    logic load;  // capture a new instruction
    logic step;  // move to the next element
  } ctrlStrobeT;

  typedef enum logic {ST_IDLE, ST_BUSY} ctrlStateT;
endpackage

// File: rtl/vexp_regtab.sv
module vexp_regtab
  import vexp_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int NPORTS  = 3,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [IDX_W-1:0]         wrIdx,
  input  tabEntryT                 wrEntry,
  input  regIdxT [NPORTS-1:0]      lookKey,
  output logic   [NPORTS-1:0]      lookVec,
  output regIdxT [NPORTS-1:0]      lookTarget
);
  tabEntryT tab [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) tab[e] <= '0;
    end else if (wrEn && (int'(wrIdx) < ENTRIES)) begin
      tab[wrIdx] <= wrEntry;
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic   hitVec;
    regIdxT hitTgt;
    // scan from the top so the lowest matching index is the last to assign
    always_comb begin
      hitVec = 1'b0;
      hitTgt = lookKey[p];
      for (int e = ENTRIES - 1; e >= 0; e--) begin
        if (tab[e].valid && (tab[e].key == lookKey[p])) begin
          hitVec = tab[e].isVec;
          hitTgt = tab[e].isVec ? tab[e].target : lookKey[p];
        end
      end
    end
    assign lookVec[p]    = hitVec;
    assign lookTarget[p] = hitTgt;
  end
endmodule

// File: rtl/vexp_dpath.sv
module vexp_dpath
  import vexp_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int MAX_VL = 16,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int CNT_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobeT            strobe,
  input  logic [OP_W-1:0]       inOp,
  input  logic   [N_OPND-1:0]   lookVec,
  input  regIdxT [N_OPND-1:0]   lookTarget,
  input  logic [VL_W-1:0]       vecLen,
  input  logic [MAX_VL-1:0]     predMask,
  output logic                  curBit,
  output logic                  lastElem,
  output logic                  loadEmpty,
  output logic                  loadOverflow,
  output logic [OP_W-1:0]       outOp,
  output regIdxT [N_OPND-1:0]   outRegs
);
  localparam int SUM_W = ((VL_W > REG_W) ? VL_W : REG_W) + 1;

  logic [VL_W-1:0]     vlEff;
  logic [MAX_VL-1:0]   vlMask;
  logic [MAX_VL-1:0]   effMask;
  logic [N_OPND-1:0]   opndOvf;

  logic [OP_W-1:0]     opR;
  regIdxT [N_OPND-1:0] baseR;
  logic [N_OPND-1:0]   vecR;
  logic [MAX_VL-1:0]   maskR;
  logic [CNT_W-1:0]    lastR;
  logic [CNT_W-1:0]    idx;

  assign vlEff = (vecLen > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vecLen;

  always_comb begin
    for (int i = 0; i < MAX_VL; i++) vlMask[i] = (VL_W'(i) < vlEff);
  end
  assign effMask   = predMask & vlMask;
  assign loadEmpty = (effMask == '0);

  for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
    // base + VL - 1 > 31  <=>  base + VL > 32
    assign opndOvf[k] = lookVec[k] && (vlEff != '0) &&
                        ((SUM_W'(lookTarget[k]) + SUM_W'(vlEff)) > SUM_W'(NUM_REGS));
    assign outRegs[k] = baseR[k] + (vecR[k] ? REG_W'(idx) : REG_W'(0));
  end
  assign loadOverflow = |opndOvf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR   <= '0;
      baseR <= '0;
      vecR  <= '0;
      maskR <= '0;
      lastR <= '0;
      idx   <= '0;
    end else if (strobe.load) begin
      opR   <= inOp;
      baseR <= lookTarget;
      vecR  <= lookVec;
      maskR <= effMask;
      lastR <= CNT_W'(vlEff - VL_W'(1));
      idx   <= '0;
    end else if (strobe.step) begin
      idx <= idx + CNT_W'(1);
    end
  end

  assign curBit   = maskR[idx];
  assign lastElem = (idx == lastR);
  assign outOp    = opR;
endmodule

// File: rtl/vexp_ctrl.sv
module vexp_ctrl
  import vexp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  input  logic       curBit,
  input  logic       lastElem,
  input  logic       loadEmpty,
  input  logic       loadOverflow,
  output logic       inReady,
  output logic       outValid,
  output logic       excValid,
  output ctrlStrobeT strobe
);
  ctrlStateT st;
  logic      excR;
  logic      accept;
  logic      advance;

  assign inReady  = (st == ST_IDLE);
  assign accept   = inValid && inReady;
  assign outValid = (st == ST_BUSY) && curBit;
  assign advance  = (st == ST_BUSY) && (!curBit || outReady);
  assign excValid = excR;

  always_comb begin
    strobe      = '0;
    strobe.load = accept;
    strobe.step = advance;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st   <= ST_IDLE;
      excR <= 1'b0;
    end else begin
      excR <= accept && loadOverflow;
      unique case (st)
        ST_IDLE: if (accept && !loadOverflow && !loadEmpty) st <= ST_BUSY;
        ST_BUSY: if (advance && lastElem) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vec_expander.sv
module vec_expander
  import vexp_pkg::*;
#(
  parameter int OP_W        = 8,
  parameter int MAX_VL      = 16,
  parameter int TAB_ENTRIES = 16,
  localparam int VL_W       = $clog2(MAX_VL + 1),
  localparam int TAB_IDX_W  = (TAB_ENTRIES > 1) ? $clog2(TAB_ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [OP_W-1:0]      inOp,
  input  logic [4:0]           inRd,
  input  logic [4:0]           inRs1,
  input  logic [4:0]           inRs2,
  input  logic [VL_W-1:0]      vecLen,
  input  logic [MAX_VL-1:0]    predMask,
  input  logic                 cfgWrEn,
  input  logic [TAB_IDX_W-1:0] cfgWrIdx,
  input  logic                 cfgWrValid,
  input  logic [4:0]           cfgWrKey,
  input  logic                 cfgWrIsVec,
  input  logic [4:0]           cfgWrTarget,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [OP_W-1:0]      outOp,
  output logic [4:0]           outRd,
  output logic [4:0]           outRs1,
  output logic [4:0]           outRs2,
  output logic                 excValid
);
  ctrlStrobeT          strobe;
  tabEntryT            wrEntry;
  regIdxT [N_OPND-1:0] lookKey;
  logic   [N_OPND-1:0] lookVec;
  regIdxT [N_OPND-1:0] lookTarget;
  regIdxT [N_OPND-1:0] outRegs;
  logic curBit, lastElem, loadEmpty, loadOverflow;

  assign wrEntry = '{valid: cfgWrValid, key: cfgWrKey, isVec: cfgWrIsVec, target: cfgWrTarget};
  assign lookKey = {inRs2, inRs1, inRd};

  vexp_regtab #(.ENTRIES(TAB_ENTRIES), .NPORTS(N_OPND)) regtab_i (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .wrIdx(cfgWrIdx), .wrEntry(wrEntry),
    .lookKey(lookKey), .lookVec(lookVec), .lookTarget(lookTarget)
  );

  vexp_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .curBit(curBit), .lastElem(lastElem), .loadEmpty(loadEmpty),
    .loadOverflow(loadOverflow), .inReady(inReady), .outValid(outValid),
    .excValid(excValid), .strobe(strobe)
  );

  vexp_dpath #(.OP_W(OP_W), .MAX_VL(MAX_VL)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inOp(inOp),
    .lookVec(lookVec), .lookTarget(lookTarget), .vecLen(vecLen), .predMask(predMask),
    .curBit(curBit), .lastElem(lastElem), .loadEmpty(loadEmpty),
    .loadOverflow(loadOverflow), .outOp(outOp), .outRegs(outRegs)
  );

  assign outRd  = outRegs[0];
  assign outRs1 = outRegs[1];
  assign outRs2 = outRegs[2];
endmodule

// File: rtl/vexp_checker.sv
module vexp_checker #(
  parameter int OP_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic            inReady,
  input logic            outValid,
  input logic            outReady,
  input logic [OP_W-1:0] outOp,
  input logic [4:0]      outRd,
  input logic [4:0]      outRs1,
  input logic [4:0]      outRs2,
  input logic            excValid
);
  assert_busy_blocks_input_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  assert_hold_when_stalled_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable({outOp, outRd, outRs1, outRs2})));

  assert_exc_one_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    excValid |=> !excValid);

  assert_exc_after_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> $past(inValid && inReady));

  assert_exc_no_uop_R7: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> !outValid);
endmodule

bind vec_expander vexp_checker #(.OP_W(OP_W)) checker_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outOp(outOp), .outRd(outRd),
  .outRs1(outRs1), .outRs2(outRs2), .excValid(excValid)
);

// File: tb/vec_expander_tb.sv
`timescale 1ns/1ps
module vec_expander_tb_top;
  localparam int OP_W = 8;
  localparam int MAXV = 16;
  localparam int NENT = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inReady;
  logic [OP_W-1:0] inOp = '0;
  logic [4:0] inRd = '0, inRs1 = '0, inRs2 = '0;
  logic [4:0] vecLen = '0;
  logic [MAXV-1:0] predMask = '0;
  logic cfgWrEn = 1'b0, cfgWrValid = 1'b0, cfgWrIsVec = 1'b0;
  logic [3:0] cfgWrIdx = '0;
  logic [4:0] cfgWrKey = '0, cfgWrTarget = '0;
  logic outValid, outReady = 1'b1, excValid;
  logic [OP_W-1:0] outOp;
  logic [4:0] outRd, outRs1, outRs2;

  int nChecks = 0;
  int nFail   = 0;

  // bench copy of the table contents, as written
  bit bValid [NENT];
  int bKey   [NENT];
  bit bVec   [NENT];
  int bTgt   [NENT];

  logic [22:0] expWord [64];
  logic [22:0] gotWord [64];
  int expN, gotN;

  always #2 clk = ~clk;

  vec_expander dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inOp(inOp),
    .inRd(inRd), .inRs1(inRs1), .inRs2(inRs2), .vecLen(vecLen), .predMask(predMask),
    .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx), .cfgWrValid(cfgWrValid), .cfgWrKey(cfgWrKey),
    .cfgWrIsVec(cfgWrIsVec), .cfgWrTarget(cfgWrTarget), .outValid(outValid),
    .outReady(outReady), .outOp(outOp), .outRd(outRd), .outRs1(outRs1),
    .outRs2(outRs2), .excValid(excValid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void lookup(input int r, output bit v, output int t);
    v = 1'b0; t = r;
    for (int e = NENT - 1; e >= 0; e--) begin
      if (bValid[e] && bKey[e] == r) begin
        v = bVec[e];
        t = bVec[e] ? bTgt[e] : r;
      end
    end
  endfunction

  task automatic wrEntry(input int idx, input bit v, input int key, input bit vec, input int tgt);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrIdx = 4'(idx); cfgWrValid = v; cfgWrKey = 5'(key);
    cfgWrIsVec = vec; cfgWrTarget = 5'(tgt);
    bValid[idx] = v; bKey[idx] = key; bVec[idx] = vec; bTgt[idx] = tgt;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // drive one instruction, collect everything it produces, compare with the model
  task automatic runInstr(input string req, input logic [7:0] op, input int rd, input int rs1,
                          input int rs2, input int vl, input logic [15:0] mask, input bit stall);
    bit vv [3];
    int tt [3];
    int regs [3];
    int vlE;
    bit expExc;
    int excSeen;
    bit prevStall;
    logic [22:0] prevWord;
    regs[0] = rd; regs[1] = rs1; regs[2] = rs2;
    for (int k = 0; k < 3; k++) lookup(regs[k], vv[k], tt[k]);
    vlE = (vl > MAXV) ? MAXV : vl;
    expExc = 1'b0;
    for (int k = 0; k < 3; k++) if (vv[k] && vlE > 0 && tt[k] + vlE > 32) expExc = 1'b1;
    expN = 0;
    if (!expExc) begin
      for (int i = 0; i < vlE; i++) begin
        if (mask[i]) begin
          expWord[expN] = {op, 5'(tt[0] + (vv[0] ? i : 0)), 5'(tt[1] + (vv[1] ? i : 0)),
                           5'(tt[2] + (vv[2] ? i : 0))};
          expN++;
        end
      end
    end
    gotN = 0; excSeen = 0; prevStall = 1'b0; prevWord = '0;
    @(negedge clk);
    chk(inReady == 1'b1, "R9", "idle before issue", longint'(inReady), 1);
    inValid = 1'b1; inOp = op; inRd = 5'(rd); inRs1 = 5'(rs1); inRs2 = 5'(rs2);
    vecLen = 5'(vl); predMask = mask;
    @(negedge clk);
    inValid = 1'b0; vecLen = '0; predMask = '0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      outReady = stall ? cyc[0] : 1'b1;
      #1;
      if (outValid && inReady)
        chk(1'b0, "R9", "inReady high during expansion", 1, 0);
      if (prevStall && !(outValid && {outOp, outRd, outRs1, outRs2} == prevWord))
        chk(1'b0, "R10", "micro-op changed while stalled", longint'({outOp, outRd, outRs1, outRs2}),
            longint'(prevWord));
      prevStall = outValid && !outReady;
      prevWord  = {outOp, outRd, outRs1, outRs2};
      if (outValid && outReady && gotN < 64) begin
        gotWord[gotN] = {outOp, outRd, outRs1, outRs2};
        gotN++;
      end
      if (excValid) excSeen++;
      if (inReady) break;
      @(negedge clk);
    end
    @(negedge clk);
    #1;
    if (excValid) excSeen++;
    outReady = 1'b1;
    chk(gotN == expN, req, "micro-op count", gotN, expN);
    for (int i = 0; i < expN && i < gotN; i++)
      chk(gotWord[i] == expWord[i], req, $sformatf("micro-op %0d", i),
          longint'(gotWord[i]), longint'(expWord[i]));
    chk(excSeen == int'(expExc), req, "exception pulses", excSeen, int'(expExc));
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(inReady == 1'b1, "R1", "inReady after reset", longint'(inReady), 1);
    chk(outValid == 1'b0, "R1", "outValid after reset", longint'(outValid), 0);
    chk(excValid == 1'b0, "R1", "excValid after reset", longint'(excValid), 0);
  endtask

  task automatic testAllScalar();   // R1 empty table, R5 scalar operands fixed
    runInstr("R1", 8'h33, 5, 6, 7, 4, 16'hffff, 1'b0);
    chk(expWord[3] == {8'h33, 5'd5, 5'd6, 5'd7}, "R5", "scalar model sanity",
        longint'(expWord[3]), longint'({8'h33, 5'd5, 5'd6, 5'd7}));
  endtask

  task automatic testExample();     // R3, R5: rd and rs1 vectors, rs2 scalar
    wrEntry(0, 1'b1, 7, 1'b1, 7);
    wrEntry(1, 1'b1, 1, 1'b1, 1);
    runInstr("R5", 8'h01, 7, 1, 4, 3, 16'hffff, 1'b0);
    chk(expWord[2] == {8'h01, 5'd9, 5'd3, 5'd4}, "R5", "third element model",
        longint'(expWord[2]), longint'({8'h01, 5'd9, 5'd3, 5'd4}));
  endtask

  task automatic testRemap();       // R3: redirect 10 -> 20
    wrEntry(2, 1'b1, 10, 1'b1, 20);
    runInstr("R3", 8'h02, 10, 10, 0, 2, 16'h0003, 1'b0);
  endtask

  task automatic testPredicate();   // R4, R6: masked elements still advance the offset
    runInstr("R6", 8'h03, 7, 1, 4, 6, 16'b101010, 1'b0);
    runInstr("R4", 8'h03, 7, 1, 4, 6, 16'b000001, 1'b0);
  endtask

  task automatic testEmpty();       // R8
    runInstr("R8", 8'h04, 7, 1, 4, 0, 16'hffff, 1'b0);
    runInstr("R8", 8'h04, 7, 1, 4, 4, 16'hfff0, 1'b0);
  endtask

  task automatic testClamp();       // R4: VL above MAX_VL
    runInstr("R4", 8'h05, 3, 3, 3, 20, 16'hffff, 1'b0);
  endtask

  task automatic testOverflow();    // R7
    wrEntry(3, 1'b1, 12, 1'b1, 30);
    runInstr("R7", 8'h06, 12, 0, 0, 3, 16'hffff, 1'b0);
    runInstr("R7", 8'h06, 0, 12, 0, 3, 16'h0000, 1'b0);
    wrEntry(3, 1'b1, 12, 1'b1, 29);
    runInstr("R7", 8'h06, 12, 0, 0, 3, 16'hffff, 1'b0);
  endtask

  task automatic testBackpressure(); // R10, R9
    runInstr("R10", 8'h07, 7, 1, 4, 5, 16'b11011, 1'b1);
  endtask

  task automatic testPriority();    // R2
    wrEntry(4, 1'b1, 15, 1'b1, 3);
    wrEntry(5, 1'b1, 15, 1'b1, 25);
    runInstr("R2", 8'h08, 15, 2, 2, 2, 16'h0003, 1'b0);
    wrEntry(4, 1'b0, 15, 1'b1, 3);
    runInstr("R2", 8'h08, 15, 2, 2, 2, 16'h0003, 1'b0);
    wrEntry(6, 1'b1, 16, 1'b0, 9);
    runInstr("R2", 8'h08, 16, 16, 2, 2, 16'h0003, 1'b0);
  endtask

  initial begin
    for (int e = 0; e < NENT; e++) begin
      bValid[e] = 1'b0; bKey[e] = 0; bVec[e] = 1'b0; bTgt[e] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testAllScalar();
    testExample();
    testRemap();
    testPredicate();
    testEmpty();
    testClamp();
    testOverflow();
    testBackpressure();
    testPriority();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #400000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule